// File: doc/BRIEF.md
# Periodic Tick Timer with Selectable Prescale

This block raises an interrupt at a fixed, programmable interval. It runs from a slow reference: each `ref_tick` input pulse is one cycle of a low-frequency source such as a 32.768 kHz crystal, brought into the system clock domain as a single-cycle enable.

An 8-bit period value programs a down-counter. The down-counter steps once per base tick. A base tick is `BASE_DIV` reference cycles by default. With the prescale enable set, a base tick is `PRE_DIV` reference cycles instead. With the default values of 4 and 2048 on a 32.768 kHz reference, one period count lasts about 122 µs, or 62.5 ms with prescale. Loading 16 with prescale gives one interrupt per second, which suits a real-time-clock tick. On every expiry the counter reloads itself, and a sticky interrupt flag is set until software clears it.

A debug freeze input can stop the count. It only has this effect when the freeze-gating control is set. A period value of zero parks the timer.

The control state machine has three states:
- `ST_IDLE`: the period is zero.
- `ST_RUN`: the timer is counting.
- `ST_HOLD`: the timer is frozen.

Its transitions are:
- `LOAD_RUN`: a nonzero write while freeze is not active, taken from any state, goes to `ST_RUN`.
- `LOAD_HOLD`: a nonzero write while freeze is active goes to `ST_HOLD`.
- `LOAD_ZERO`: a write of zero, taken from any state, goes to `ST_IDLE`.
- `FREEZE`: `ST_RUN` goes to `ST_HOLD` when freeze becomes active.
- `THAW`: `ST_HOLD` goes to `ST_RUN` when freeze ends.

A write takes precedence over freeze transitions in the same cycle.

Top module: `periodic_irq_timer`

## Requirements
- R1: With `pre_en` low, a nonzero period P produces an expiry after exactly P×`BASE_DIV` reference ticks. `irq` reads 1 in the clock cycle after the edge that sampled the final tick.
- R2: With `pre_en` high, a nonzero period P expires after exactly P×`PRE_DIV` reference ticks. This holds from P=1 up to P=255.
- R3: On expiry the counter reloads from the stored period in that same cycle. Each following period is again exactly P base ticks, with no drift.
- R4: A stored period of 0 parks the block in `ST_IDLE`. No interrupt is produced and `running` is 0.
- R5: Writing a period value clears the prescale count and reloads the down-counter. The next expiry then comes a full period after the write.
- R6: While `frz_in` and `frz_gate` are both 1, the count stops and `running` is 0. When freeze ends, the count resumes from where it stopped.
- R7: `frz_in` has no effect when `frz_gate` is 0.
- R8: `irq` is a level flag. It stays 1 until `irq_clr` is pulsed in a cycle with no expiry.
- R9: An expiry in the same cycle as `irq_clr` leaves `irq` at 1.
- R10: After reset, `irq` and `running` are 0 and the state is `ST_IDLE`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_tick | input | 1 | One-cycle enable per reference clock cycle |
| per_wr | input | 1 | Period write strobe |
| per_wdata | input | PERIOD_W | Period value to store |
| pre_en | input | 1 | 1 selects the long `PRE_DIV` base tick |
| frz_in | input | 1 | Debug freeze request |
| frz_gate | input | 1 | 1 lets freeze halt the timer |
| irq_clr | input | 1 | Clears the interrupt flag |
| irq | output | 1 | Sticky interrupt request |
| running | output | 1 | 1 while in `ST_RUN` |

## Verification
The bench builds the block with `PERIOD_W`=8, `BASE_DIV`=4 and `PRE_DIV`=32. A small prescale ratio keeps a full 255-count prescaled period within about 16k clock cycles. Every tick count can then be checked exactly, including the longest period and the one-count period. The mux choice between the two ratios and the wrap logic of the prescale counter are the same as at the default ratio of 2048.

// File: rtl/pit_pkg.sv
package pit_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_HOLD = 2'd2
    } pit_state_e;

endpackage

// File: rtl/pit_prescaler.sv
module pit_prescaler #(
    parameter int BASE_DIV = 4,
    parameter int PRE_DIV  = 2048
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_tick,
    input  logic run_en,
    input  logic clr,
    input  logic pre_en,
    output logic base_tick
);
    localparam int MAX_DIV = (PRE_DIV > BASE_DIV) ? PRE_DIV : BASE_DIV;
    localparam int DIV_W   = $clog2(MAX_DIV) + 1;
    localparam logic [DIV_W-1:0] BASE_LAST = DIV_W'(BASE_DIV - 1);
    localparam logic [DIV_W-1:0] PRE_LAST  = DIV_W'(PRE_DIV - 1);

    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] last;
    logic             step;
    logic             wrap;

    always_comb begin
        last = pre_en ? PRE_LAST : BASE_LAST;
        step = ref_tick && run_en && !clr;
        wrap = (div_q >= last);
        base_tick = step && wrap;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
        end else if (clr) begin
            div_q <= '0;
        end else if (step) begin
            div_q <= wrap ? '0 : div_q + 1'b1;
        end
    end

    AST_DIV_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        div_q <= DIV_W'(MAX_DIV - 1)) else $error("prescale count out of range"); // R2

    AST_CLR_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> div_q == '0) else $error("write did not clear prescale"); // R5

endmodule

// File: rtl/pit_counter.sv
module pit_counter #(
    parameter int PERIOD_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [PERIOD_W-1:0] wr_data,
    input  logic                base_tick,
    output logic                expire
);
    localparam logic [PERIOD_W-1:0] ONE = PERIOD_W'(1);

    logic [PERIOD_W-1:0] per_q;
    logic [PERIOD_W-1:0] cnt_q;

    always_comb begin
        expire = base_tick && !wr_en && (cnt_q == ONE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            per_q <= '0;
            cnt_q <= '0;
        end else if (wr_en) begin
            per_q <= wr_data;
            cnt_q <= wr_data;
        end else if (base_tick) begin
            cnt_q <= expire ? per_q : cnt_q - 1'b1;
        end
    end

    AST_RELOAD_ON_EXPIRE: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> cnt_q == $past(per_q)) else $error("no reload on expiry"); // R3

    AST_WRITE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (cnt_q == $past(wr_data)) && (per_q == $past(wr_data))) else $error("write did not load"); // R5

    AST_COUNT_NOT_ABOVE_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= per_q) else $error("count above period"); // R3

endmodule

// File: rtl/pit_ctrl.sv
module pit_ctrl
    import pit_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic wr_zero,
    input  logic frz_in,
    input  logic frz_gate,
    input  logic expire_i,
    input  logic irq_clr,
    output logic run_en,
    output logic running,
    output logic irq
);
    pit_state_e state_q;
    pit_state_e state_d;
    logic       frz_act;
    logic       irq_q;

    assign frz_act = frz_in && frz_gate;

    always_comb begin
        state_d = state_q;
        if (wr_en) begin
            if (wr_zero)      state_d = ST_IDLE;   // LOAD_ZERO
            else if (frz_act) state_d = ST_HOLD;   // LOAD_HOLD
            else              state_d = ST_RUN;    // LOAD_RUN
        end else begin
            unique case (state_q)
                ST_IDLE: state_d = ST_IDLE;
                ST_RUN:  if (frz_act)  state_d = ST_HOLD;  // FREEZE
                ST_HOLD: if (!frz_act) state_d = ST_RUN;   // THAW
                default: state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= (irq_q && !irq_clr) || expire_i;
    end

    always_comb begin
        run_en  = (state_q == ST_RUN);
        running = (state_q == ST_RUN);
        irq     = irq_q;
    end

    AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> !expire_i) else $error("expiry while idle"); // R4

    AST_HOLD_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD) |-> !expire_i) else $error("expiry while frozen"); // R6

    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_q && !irq_clr) |=> irq_q) else $error("irq dropped without clear"); // R8

    AST_EXPIRE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        expire_i |=> irq_q) else $error("expiry lost"); // R9

    AST_GATE_OFF_NO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!frz_gate && !wr_en && state_q == ST_RUN) |=> state_q == ST_RUN) else $error("ungated freeze halted"); // R7

endmodule

// File: rtl/periodic_irq_timer.sv
module periodic_irq_timer #(
    parameter int PERIOD_W = 8,
    parameter int BASE_DIV = 4,
    parameter int PRE_DIV  = 2048
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ref_tick,
    input  logic                per_wr,
    input  logic [PERIOD_W-1:0] per_wdata,
    input  logic                pre_en,
    input  logic                frz_in,
    input  logic                frz_gate,
    input  logic                irq_clr,
    output logic                irq,
    output logic                running
);
    logic run_en;
    logic base_tick;
    logic expire;
    logic wr_zero;

    assign wr_zero = (per_wdata == '0);

    pit_prescaler #(
        .BASE_DIV (BASE_DIV),
        .PRE_DIV  (PRE_DIV)
    ) u_pre (
        .clk       (clk),
        .rst_n     (rst_n),
        .ref_tick  (ref_tick),
        .run_en    (run_en),
        .clr       (per_wr),
        .pre_en    (pre_en),
        .base_tick (base_tick)
    );

    pit_counter #(
        .PERIOD_W (PERIOD_W)
    ) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (per_wr),
        .wr_data   (per_wdata),
        .base_tick (base_tick),
        .expire    (expire)
    );

    pit_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (per_wr),
        .wr_zero  (wr_zero),
        .frz_in   (frz_in),
        .frz_gate (frz_gate),
        .expire_i (expire),
        .irq_clr  (irq_clr),
        .run_en   (run_en),
        .running  (running),
        .irq      (irq)
    );

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (!irq && !running)) else $error("not quiet after reset"); // R10

endmodule

// File: tb/periodic_irq_timer_tb.sv
module periodic_irq_timer_tb;
    localparam int PW = 8;
    localparam int BD = 4;
    localparam int PD = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ref_tick = 1'b0;
    logic          per_wr = 1'b0;
    logic [PW-1:0] per_wdata = '0;
    logic          pre_en = 1'b0;
    logic          frz_in = 1'b0;
    logic          frz_gate = 1'b0;
    logic          irq_clr = 1'b0;
    logic          irq;
    logic          running;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    periodic_irq_timer #(.PERIOD_W(PW), .BASE_DIV(BD), .PRE_DIV(PD)) u_dut (
        .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .per_wr(per_wr),
        .per_wdata(per_wdata), .pre_en(pre_en), .frz_in(frz_in),
        .frz_gate(frz_gate), .irq_clr(irq_clr), .irq(irq), .running(running)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk) ref_tick = 1'b1;
        @(negedge clk) ref_tick = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic wr(input int v);
        @(negedge clk) begin per_wr = 1'b1; per_wdata = PW'(v); end
        @(negedge clk) per_wr = 1'b0;
    endtask

    task automatic clr();
        @(negedge clk) irq_clr = 1'b1;
        @(negedge clk) irq_clr = 1'b0;
    endtask

    task automatic measure(output int n, input int max);
        n = 0;
        while (!irq && n < max) begin
            tick();
            n++;
        end
    endtask

    task automatic t_reset();
        check("R10 irq", int'(irq), 0);
        check("R10 running", int'(running), 0);
    endtask

    task automatic t_base();
        int n;
        pre_en = 1'b0;
        wr(5);
        check("R1 running", int'(running), 1);
        measure(n, 1000);
        check("R1 base period", n, 5 * BD);
        clr();
        measure(n, 1000);
        check("R3 next period no drift", n, 5 * BD);
        clr();
    endtask

    task automatic t_prescale();
        int n;
        pre_en = 1'b1;
        wr(16);
        measure(n, 20000);
        check("R2 period 16", n, 16 * PD);
        clr();
        wr(1);
        measure(n, 20000);
        check("R2 period 1", n, PD);
        clr();
        wr(255);
        measure(n, 20000);
        check("R2 period 255", n, 255 * PD);
        clr();
        pre_en = 1'b0;
    endtask

    task automatic t_zero();
        wr(0);
        ticks(100);
        check("R4 irq", int'(irq), 0);
        check("R4 running", int'(running), 0);
    endtask

    task automatic t_restart();
        int n;
        wr(5);
        ticks(10);
        wr(5);
        measure(n, 1000);
        check("R5 restart", n, 5 * BD);
        clr();
    endtask

    task automatic t_freeze();
        int n;
        wr(2);
        ticks(3);
        @(negedge clk) begin frz_in = 1'b1; frz_gate = 1'b1; end
        repeat (2) @(negedge clk);
        check("R6 running frozen", int'(running), 0);
        ticks(50);
        check("R6 no irq frozen", int'(irq), 0);
        @(negedge clk) frz_in = 1'b0;
        repeat (2) @(negedge clk);
        check("R6 running resumed", int'(running), 1);
        measure(n, 1000);
        check("R6 remaining", n, 2 * BD - 3);
        clr();
        frz_gate = 1'b0;
    endtask

    task automatic t_ungated();
        int n;
        frz_in = 1'b1;
        frz_gate = 1'b0;
        wr(2);
        repeat (2) @(negedge clk);
        check("R7 running", int'(running), 1);
        measure(n, 1000);
        check("R7 full period", n, 2 * BD);
        clr();
        frz_in = 1'b0;
    endtask

    task automatic t_level();
        wr(1);
        ticks(BD);
        check("R8 set", int'(irq), 1);
        repeat (5) @(negedge clk);
        check("R8 held", int'(irq), 1);
        clr();
        check("R8 cleared", int'(irq), 0);
    endtask

    task automatic t_collide();
        wr(1);
        ticks(BD);
        ticks(BD - 1);
        @(negedge clk) begin ref_tick = 1'b1; irq_clr = 1'b1; end
        @(negedge clk) begin ref_tick = 1'b0; irq_clr = 1'b0; end
        check("R9 expire beats clear", int'(irq), 1);
        clr();
        check("R9 later clear", int'(irq), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_base();
        t_prescale();
        t_zero();
        t_restart();
        t_freeze();
        t_ungated();
        t_level();
        t_collide();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule